// File: doc/BRIEF.md
# Flow-Controlled Serial Receive Buffer

This block is the receive side of an asynchronous serial link running at a fixed 9600 baud with 8 data bits, no parity and one stop bit. Characters arriving on either of two receive inputs are assembled by an oversampling receiver and stored in a deep character queue. A downstream consumer removes them at its own pace through a valid/ready pop port.

A slow consumer could let the queue overrun. To prevent this, the block watches its own fill level and throttles the remote sender in band. When the level climbs to a high mark, it sends the stop character 0x13 on its transmit line. It sends the resume character 0x11 only once the level has fallen back to a low mark. The gap between the two marks provides hysteresis, so the link does not chatter. The transmitter carries nothing except these two characters.

Both receive inputs may be wired at the same time, although only one is expected to be active. Each input is synchronized and treated as idle-high, and the two are then merged into a single line. A disconnected input therefore never starts a frame. The default configuration holds 1000 characters, sends the stop character at 900 and the resume character at 100.

Top module: `serial_flow_buffer`

## Requirements
- R1: Each frame is received as a low start bit, 8 data bits least significant first, and a high stop bit. Every bit lasts 16 oversample ticks, and the oversample tick rate is 16 times 9600 Hz derived from the clock parameter.
- R2: A falling edge on the merged line starts a frame only if the line is still low at the middle of the start bit. A low pulse shorter than half a bit stores nothing and raises no error.
- R3: A frame whose stop bit samples low is dropped and raises `frameErrPulse` for exactly one clock cycle.
- R4: The two receive inputs are synchronized, reset to high, and combined by logical AND. A frame on either input, with the other input held high, is received.
- R5: The queue returns characters in arrival order and holds up to FIFO_DEPTH characters.
- R6: `popData` shows the oldest character while `popValid` is high. A character is removed on a clock edge where `popValid` and `popReady` are both high. While `popValid` is high and `popReady` is low, `popValid` and `popData` stay unchanged.
- R7: A character that completes while the queue is full is discarded. It also sets `overflowFlag`, which stays high until reset.
- R8: When the fill level reaches XOFF_LEVEL, the stop character 0x13 is transmitted exactly once. It is not sent again while the level stays at or above that mark.
- R9: After a stop character, the resume character 0x11 is transmitted exactly once, when the fill level falls to XON_LEVEL or below. No resume character is sent while the level lies between the marks.
- R10: `txLine` idles high and carries only the flow-control characters. Each one is sent in the same 8N1 format, least significant bit first, with a high stop bit.
- R11: A character stored in the same cycle as a pop leaves the fill level unchanged, and no character is lost or reordered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| rxLineA | input | 1 | First serial receive input, idle high |
| rxLineB | input | 1 | Second serial receive input, idle high |
| txLine | output | 1 | Serial transmit line carrying stop/resume characters |
| popValid | output | 1 | Queue holds at least one character |
| popData | output | 8 | Oldest stored character |
| popReady | input | 1 | Consumer accepts the character on this edge |
| frameErrPulse | output | 1 | One-cycle pulse on a dropped frame with a low stop bit |
| overflowFlag | output | 1 | Sticky flag: a character was discarded because the queue was full |

## Verification
Storing a received character and popping one can fall in the same clock cycle. To provoke this, the bench first loads ten characters into the queue. It then starts one more frame and holds `popReady` high over a sixteen-cycle window around the computed stop-bit sample point, so that a write lands while reads are in progress. The test is judged at the ports: all eleven characters must come out in arrival order, the queue must then be empty, and no overflow may be flagged. A second pairing is the flow-control threshold crossing while frames keep arriving. Here the bench decodes `txLine` and counts exactly one stop and one resume character across a full fill and drain.

// File: rtl/flowbuf_pkg.sv
package flowbuf_pkg;

  localparam int BAUD_RATE  = 9600;
  localparam int OVERSAMPLE = 16;
  localparam int DATA_BITS  = 8;

  localparam logic [7:0] STOP_CHAR   = 8'h13;
  localparam logic [7:0] RESUME_CHAR = 8'h11;

  typedef enum logic [1:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP
  } rx_state_t;

  typedef struct packed {
    logic sampleBit;
    logic pushChar;
    logic frameErr;
    logic sendStop;
    logic sendResume;
  } ctrl_strobes_t;

endpackage

// File: rtl/flowbuf_datapath.sv
module flowbuf_datapath
  import flowbuf_pkg::*;
#(
  parameter int CLK_FREQ_HZ = 50_000_000,
  parameter int FIFO_DEPTH  = 1000,
  parameter int LEVEL_W     = $clog2(FIFO_DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                rxLineA,
  input  logic                rxLineB,
  input  ctrl_strobes_t       strobes,
  input  logic                popReady,
  output logic                lineLevel,
  output logic                osTick,
  output logic [LEVEL_W-1:0]  fillLevel,
  output logic                txLine,
  output logic                popValid,
  output logic [7:0]          popData,
  output logic                overflowFlag
);

  localparam int DIV   = CLK_FREQ_HZ / (BAUD_RATE * OVERSAMPLE);
  localparam int DIV_W = $clog2(DIV + 1);
  localparam int PTR_W = (FIFO_DEPTH > 1) ? $clog2(FIFO_DEPTH) : 1;
  localparam int SUB_W = $clog2(OVERSAMPLE);
  localparam int FRAME_BITS = DATA_BITS + 2;
  localparam logic [PTR_W-1:0]   LAST_PTR = PTR_W'(FIFO_DEPTH - 1);
  localparam logic [LEVEL_W-1:0] FULL_LVL = LEVEL_W'(FIFO_DEPTH);

  // input synchronizers, one lane per receive input, idle high at reset
  logic [1:0] rxIn;
  logic [1:0] laneLevel;
  assign rxIn = {rxLineB, rxLineA};

  for (genvar lane = 0; lane < 2; lane++) begin : g_sync
    logic [1:0] syncReg;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) syncReg <= 2'b11;
      else       syncReg <= {syncReg[0], rxIn[lane]};
    end
    assign laneLevel[lane] = syncReg[1];
  end

  assign lineLevel = &laneLevel;

  // oversample tick divider
  logic [DIV_W-1:0] divCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt <= '0;
    end else if (divCnt == DIV_W'(DIV - 1)) begin
      divCnt <= '0;
    end else begin
      divCnt <= divCnt + 1'b1;
    end
  end
  assign osTick = (divCnt == DIV_W'(DIV - 1));

  // receive shift register, least significant bit first
  logic [7:0] rxShift;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  rxShift <= '0;
    else if (strobes.sampleBit) rxShift <= {lineLevel, rxShift[7:1]};
  end

  // character queue
  logic [7:0]       mem [FIFO_DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic             isFull, pushOk, popOk;

  assign isFull   = (fillLevel == FULL_LVL);
  assign pushOk   = strobes.pushChar && !isFull;
  assign popValid = (fillLevel != '0);
  assign popOk    = popValid && popReady;
  assign popData  = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (pushOk) mem[wrPtr] <= rxShift;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr        <= '0;
      rdPtr        <= '0;
      fillLevel    <= '0;
      overflowFlag <= 1'b0;
    end else begin
      if (pushOk) wrPtr <= (wrPtr == LAST_PTR) ? '0 : wrPtr + 1'b1;
      if (popOk)  rdPtr <= (rdPtr == LAST_PTR) ? '0 : rdPtr + 1'b1;
      case ({pushOk, popOk})
        2'b10:   fillLevel <= fillLevel + 1'b1;
        2'b01:   fillLevel <= fillLevel - 1'b1;
        default: fillLevel <= fillLevel;
      endcase
      if (strobes.pushChar && isFull) overflowFlag <= 1'b1;
    end
  end

  // flow-control transmitter: one pending slot, newest request wins
  logic       pendValid;
  logic [7:0] pendChar;
  logic       txBusy, txStart;
  logic [FRAME_BITS-1:0] txShift;
  logic [SUB_W-1:0]      txSub;
  logic [3:0]            txBitsLeft;

  assign txStart = pendValid && !txBusy;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendValid <= 1'b0;
      pendChar  <= '0;
    end else if (strobes.sendStop) begin
      pendValid <= 1'b1;
      pendChar  <= STOP_CHAR;
    end else if (strobes.sendResume) begin
      pendValid <= 1'b1;
      pendChar  <= RESUME_CHAR;
    end else if (txStart) begin
      pendValid <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txBusy     <= 1'b0;
      txShift    <= '1;
      txSub      <= '0;
      txBitsLeft <= '0;
    end else if (txStart) begin
      txBusy     <= 1'b1;
      txShift    <= {1'b1, pendChar, 1'b0};
      txSub      <= '0;
      txBitsLeft <= 4'(FRAME_BITS);
    end else if (txBusy && osTick) begin
      if (txSub == SUB_W'(OVERSAMPLE - 1)) begin
        txSub      <= '0;
        txShift    <= {1'b1, txShift[FRAME_BITS-1:1]};
        txBitsLeft <= txBitsLeft - 1'b1;
        if (txBitsLeft == 4'd1) txBusy <= 1'b0;
      end else begin
        txSub <= txSub + 1'b1;
      end
    end
  end

  assign txLine = txBusy ? txShift[0] : 1'b1;

  // assertions
  assert_fill_bound_R5: assert property (@(posedge clk) disable iff (!rstN)
    fillLevel <= FULL_LVL);

  assert_pop_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (popValid && !popReady && !strobes.pushChar) |=> (popValid && $stable(popData)));

  assert_overflow_sticky_R7: assert property (@(posedge clk) disable iff (!rstN)
    overflowFlag |=> overflowFlag);

  assert_full_drop_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.pushChar && isFull && !popReady) |=> (fillLevel == FULL_LVL) && overflowFlag);

  assert_push_pop_level_R11: assert property (@(posedge clk) disable iff (!rstN)
    (pushOk && popOk) |=> $stable(fillLevel));

  assert_tx_idle_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!txBusy && !pendValid) |=> txLine);

endmodule

// File: rtl/flowbuf_control.sv
module flowbuf_control
  import flowbuf_pkg::*;
#(
  parameter int FIFO_DEPTH = 1000,
  parameter int XOFF_LEVEL = 900,
  parameter int XON_LEVEL  = 100,
  parameter int LEVEL_W    = $clog2(FIFO_DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               lineLevel,
  input  logic               osTick,
  input  logic [LEVEL_W-1:0] fillLevel,
  output ctrl_strobes_t      strobes
);

  localparam int SUB_W = $clog2(OVERSAMPLE);
  localparam logic [SUB_W-1:0]   MID_TICK  = SUB_W'(OVERSAMPLE / 2 - 1);
  localparam logic [SUB_W-1:0]   LAST_TICK = SUB_W'(OVERSAMPLE - 1);
  localparam logic [LEVEL_W-1:0] HIGH_MARK = LEVEL_W'(XOFF_LEVEL);
  localparam logic [LEVEL_W-1:0] LOW_MARK  = LEVEL_W'(XON_LEVEL);

  rx_state_t        rxState;
  logic [SUB_W-1:0] tickCnt;
  logic [2:0]       bitCnt;
  logic             prevLine;
  logic             stopSent;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevLine <= 1'b1;
    else       prevLine <= lineLevel;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxState <= RX_IDLE;
      tickCnt <= '0;
      bitCnt  <= '0;
    end else begin
      case (rxState)
        RX_IDLE: begin
          if (prevLine && !lineLevel) begin
            rxState <= RX_START;
            tickCnt <= '0;
          end
        end
        RX_START: begin
          if (osTick) begin
            if (tickCnt == MID_TICK) begin
              tickCnt <= '0;
              bitCnt  <= '0;
              rxState <= lineLevel ? RX_IDLE : RX_DATA;
            end else begin
              tickCnt <= tickCnt + 1'b1;
            end
          end
        end
        RX_DATA: begin
          if (osTick) begin
            tickCnt <= tickCnt + 1'b1;
            if (tickCnt == LAST_TICK) begin
              bitCnt <= bitCnt + 1'b1;
              if (bitCnt == 3'(DATA_BITS - 1)) rxState <= RX_STOP;
            end
          end
        end
        RX_STOP: begin
          if (osTick) begin
            tickCnt <= tickCnt + 1'b1;
            if (tickCnt == LAST_TICK) rxState <= RX_IDLE;
          end
        end
        default: rxState <= RX_IDLE;
      endcase
    end
  end

  logic atBitMid;
  assign atBitMid = osTick && (tickCnt == LAST_TICK);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                   stopSent <= 1'b0;
    else if (strobes.sendStop)                   stopSent <= 1'b1;
    else if (strobes.sendResume)                 stopSent <= 1'b0;
  end

  always_comb begin
    strobes            = '0;
    strobes.sampleBit  = (rxState == RX_DATA) && atBitMid;
    strobes.pushChar   = (rxState == RX_STOP) && atBitMid && lineLevel;
    strobes.frameErr   = (rxState == RX_STOP) && atBitMid && !lineLevel;
    strobes.sendStop   = !stopSent && (fillLevel >= HIGH_MARK);
    strobes.sendResume = stopSent && (fillLevel <= LOW_MARK);
  end

  assert_stop_once_R8: assert property (@(posedge clk) disable iff (!rstN)
    strobes.sendStop |=> !strobes.sendStop);

  assert_resume_once_R9: assert property (@(posedge clk) disable iff (!rstN)
    strobes.sendResume |=> !strobes.sendResume);

  assert_err_single_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobes.frameErr |=> !strobes.frameErr);

endmodule

// File: rtl/serial_flow_buffer.sv
module serial_flow_buffer
  import flowbuf_pkg::*;
#(
  parameter int CLK_FREQ_HZ = 50_000_000,
  parameter int FIFO_DEPTH  = 1000,
  parameter int XOFF_LEVEL  = 900,
  parameter int XON_LEVEL   = 100
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       rxLineA,
  input  logic       rxLineB,
  output logic       txLine,
  output logic       popValid,
  output logic [7:0] popData,
  input  logic       popReady,
  output logic       frameErrPulse,
  output logic       overflowFlag
);

  localparam int LEVEL_W = $clog2(FIFO_DEPTH + 1);

  ctrl_strobes_t      strobes;
  logic               lineLevel;
  logic               osTick;
  logic [LEVEL_W-1:0] fillLevel;

  flowbuf_datapath #(
    .CLK_FREQ_HZ(CLK_FREQ_HZ),
    .FIFO_DEPTH (FIFO_DEPTH),
    .LEVEL_W    (LEVEL_W)
  ) u_datapath (
    .clk         (clk),
    .rstN        (rstN),
    .rxLineA     (rxLineA),
    .rxLineB     (rxLineB),
    .strobes     (strobes),
    .popReady    (popReady),
    .lineLevel   (lineLevel),
    .osTick      (osTick),
    .fillLevel   (fillLevel),
    .txLine      (txLine),
    .popValid    (popValid),
    .popData     (popData),
    .overflowFlag(overflowFlag)
  );

  flowbuf_control #(
    .FIFO_DEPTH(FIFO_DEPTH),
    .XOFF_LEVEL(XOFF_LEVEL),
    .XON_LEVEL (XON_LEVEL),
    .LEVEL_W   (LEVEL_W)
  ) u_control (
    .clk      (clk),
    .rstN     (rstN),
    .lineLevel(lineLevel),
    .osTick   (osTick),
    .fillLevel(fillLevel),
    .strobes  (strobes)
  );

  assign frameErrPulse = strobes.frameErr;

endmodule

// File: tb/serial_flow_buffer_tb.sv
module serial_flow_buffer_tb;

  localparam int CLK_PERIOD = 10;
  localparam int CLK_HZ     = 9600 * 16 * 2;
  localparam int DEPTH      = 16;
  localparam int HIGH_LVL   = 12;
  localparam int LOW_LVL    = 4;
  localparam int BIT_CYC    = 32;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       rxLineA = 1'b1;
  logic       rxLineB = 1'b1;
  logic       txLine;
  logic       popValid;
  logic [7:0] popData;
  logic       popReady = 1'b0;
  logic       frameErrPulse;
  logic       overflowFlag;

  int checks = 0;
  int failures = 0;
  int errCount = 0;
  int txCount = 0;
  int popCount = 0;
  logic [7:0] txLog [8];
  logic [7:0] popLog [512];

  always #(CLK_PERIOD / 2) clk = ~clk;

  serial_flow_buffer #(
    .CLK_FREQ_HZ(CLK_HZ),
    .FIFO_DEPTH (DEPTH),
    .XOFF_LEVEL (HIGH_LVL),
    .XON_LEVEL  (LOW_LVL)
  ) u_dut (
    .clk          (clk),
    .rstN         (rstN),
    .rxLineA      (rxLineA),
    .rxLineB      (rxLineB),
    .txLine       (txLine),
    .popValid     (popValid),
    .popData      (popData),
    .popReady     (popReady),
    .frameErrPulse(frameErrPulse),
    .overflowFlag (overflowFlag)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // record every accepted pop and every error pulse
  always @(posedge clk) begin
    if (rstN && popValid && popReady) begin
      popLog[popCount] = popData;
      popCount++;
    end
    if (rstN && frameErrPulse) errCount++;
  end

  // decode the transmit line
  initial begin
    logic [7:0] b;
    forever begin
      @(negedge txLine);
      repeat (BIT_CYC / 2) @(negedge clk);
      for (int i = 0; i < 8; i++) begin
        repeat (BIT_CYC) @(negedge clk);
        b[i] = txLine;
      end
      repeat (BIT_CYC) @(negedge clk);
      check(txLine === 1'b1, "R10 tx stop bit", txLine, 1);
      if (txCount < 8) txLog[txCount] = b;
      txCount++;
    end
  end

  task automatic sendFrame(input bit onB, input logic [7:0] b, input bit stopBit);
    logic [9:0] bits;
    bits = {stopBit, b, 1'b0};
    @(negedge clk);
    for (int i = 0; i < 10; i++) begin
      if (onB) rxLineB = bits[i]; else rxLineA = bits[i];
      repeat (BIT_CYC) @(negedge clk);
    end
    rxLineA = 1'b1;
    rxLineB = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic popPulse();
    @(negedge clk);
    popReady = 1'b1;
    @(negedge clk);
    popReady = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  bit finished = 1'b0;

  initial begin
    repeat (190_000) @(posedge clk);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
      $finish;
    end
  end

  initial begin
    int base;
    idle(5);
    // reset state
    check(popValid === 1'b0, "R5 reset empty", popValid, 0);
    check(txLine === 1'b1, "R10 reset tx idle", txLine, 1);
    check(overflowFlag === 1'b0, "R7 reset overflow", overflowFlag, 0);
    check(frameErrPulse === 1'b0, "R3 reset err", frameErrPulse, 0);
    rstN = 1'b1;
    idle(5);

    // R1 R4 frame on line A, then on line B
    sendFrame(1'b0, 8'hA5, 1'b1);
    check(popValid === 1'b1 && popData === 8'hA5, "R1 R4 line A data", popData, 8'hA5);
    // R6 hold while not ready
    idle(50);
    check(popValid === 1'b1 && popData === 8'hA5, "R6 hold stable", popData, 8'hA5);
    popPulse();
    check(popValid === 1'b0, "R6 pop removes", popValid, 0);
    sendFrame(1'b1, 8'h3C, 1'b1);
    check(popValid === 1'b1 && popData === 8'h3C, "R4 line B data", popData, 8'h3C);
    popPulse();

    // R3 framing error
    sendFrame(1'b0, 8'h5A, 1'b0);
    idle(40);
    check(errCount == 1, "R3 one error pulse", errCount, 1);
    check(popValid === 1'b0, "R3 frame dropped", popValid, 0);

    // R2 glitch shorter than half a bit
    @(negedge clk);
    rxLineA = 1'b0;
    idle(6);
    rxLineA = 1'b1;
    idle(400);
    check(popValid === 1'b0, "R2 glitch ignored", popValid, 0);
    check(errCount == 1, "R2 glitch no error", errCount, 1);

    // R11 push while popping: preload 10, pop across the stop sample
    for (int i = 0; i < 10; i++) sendFrame(i[0], 8'(8'h40 + i), 1'b1);
    base = popCount;
    fork
      sendFrame(1'b0, 8'hC7, 1'b1);
      begin
        @(negedge clk);
        idle(298);
        popReady = 1'b1;
        idle(16);
        popReady = 1'b0;
      end
    join
    while (popValid) popPulse();
    check(popCount - base == 11, "R11 count popped", popCount - base, 11);
    for (int i = 0; i < 10; i++)
      check(popLog[base + i] == 8'(8'h40 + i), "R11 R5 order", popLog[base + i], 8'h40 + i);
    check(popLog[base + 10] == 8'hC7, "R11 last char", popLog[base + 10], 8'hC7);
    check(overflowFlag === 1'b0, "R11 no overflow", overflowFlag, 0);
    check(txCount == 0, "R8 no stop below mark", txCount, 0);

    // R8 R9 R7 fill and drain
    base = popCount;
    for (int i = 0; i < HIGH_LVL - 1; i++) sendFrame(i[0], 8'(8'h80 + i), 1'b1);
    idle(400);
    check(txCount == 0, "R8 no stop at mark-1", txCount, 0);
    sendFrame(1'b1, 8'(8'h80 + HIGH_LVL - 1), 1'b1);
    idle(400);
    check(txCount == 1 && txLog[0] == 8'h13, "R8 stop char sent", txLog[0], 8'h13);
    for (int i = HIGH_LVL; i < DEPTH; i++) sendFrame(1'b0, 8'(8'h80 + i), 1'b1);
    check(overflowFlag === 1'b0, "R7 full no overflow", overflowFlag, 0);
    sendFrame(1'b0, 8'hEE, 1'b1);
    check(overflowFlag === 1'b1, "R7 overflow set", overflowFlag, 1);
    idle(400);
    check(txCount == 1, "R8 stop sent once", txCount, 1);
    for (int i = 0; i < DEPTH - LOW_LVL - 1; i++) popPulse();
    idle(400);
    check(txCount == 1, "R9 no resume above low mark", txCount, 1);
    popPulse();
    idle(400);
    check(txCount == 2 && txLog[1] == 8'h11, "R9 resume char sent", txLog[1], 8'h11);
    while (popValid) popPulse();
    idle(400);
    check(txCount == 2, "R9 resume once", txCount, 2);
    check(popCount - base == DEPTH, "R5 depth held", popCount - base, DEPTH);
    for (int i = 0; i < DEPTH; i++)
      check(popLog[base + i] == 8'(8'h80 + i), "R5 R7 order kept", popLog[base + i], 8'h80 + i);
    check(overflowFlag === 1'b1, "R7 overflow sticky", overflowFlag, 1);

    // R1 exhaustive byte sweep on alternating inputs
    for (int v = 0; v < 256; v++) begin
      sendFrame(v[0], 8'(v), 1'b1);
      check(popValid === 1'b1 && popData === 8'(v), "R1 R4 sweep", popData, v);
      popPulse();
    end
    check(errCount == 1, "R3 no stray errors", errCount, 1);
    check(txCount == 2, "R10 only flow chars", txCount, 2);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
    $finish;
  end

endmodule